// File: doc/BRIEF.md
# Table-Driven Instruction Control Decoder

This block turns the opcode and function fields of a 32-bit instruction into the control word that steers a single-cycle datapath. It does no sequencing. A one-level index mux picks a line of a 128-line read-only table, and the stored word drives the datapath's control wires. To change the instruction set, edit the table contents. The logic does not change.

The table needs only 128 lines because of how the index is built. Any nonzero opcode selects its own line in the lower half. Opcode 0 has no line of its own. Instead, the function field selects a line in the upper half. So a single table covers plain opcodes and opcode/function pairs alike.

The table read is registered, so a block RAM can hold the table. The word appears one clock after the fields are presented.

Top module: `ctl_lut_decoder`

## Requirements
- R1: For a nonzero opcode, the table line is the opcode value itself. The function field then has no effect on the output.
- R2: For opcode 0, the table line is 64 plus the function value. For example, opcode 0 with function 0x20 reads line 0x60.
- R3: The control word is registered. Fields present at a rising edge appear on `ctl_word` after that edge. The output holds its value until the next edge.
- R4: While the synchronous active-high reset is high, `ctl_word` is all zero at every edge, whatever the inputs.
- R5: Every table line not listed in R7 to R10 reads as all zero. This includes opcode 0 with function 0.
- R6: Bit layout of `ctl_word`:
  - bit 0: register write
  - bit 1: destination from rd field
  - bit 2: ALU second operand is the immediate
  - bits 6:3: ALU operation
  - bit 7: memory write
  - bit 8: load result to register
  - bit 9: branch on equal
  - bit 10: branch on not equal
  - bit 11: jump
  - bit 12: link
  - bit 13: jump to register
  - bit 14: zero-extend immediate
  - bit 15: halt

  The ALU operation codes are: add 0, subtract 1, and 2, or 3, nor 4, xor 5, signed less-than 6, unsigned less-than 7, load-upper 8.
- R7: The register-form lines set register write and destination-from-rd, plus the ALU code. Function codes 0x20 and 0x21 give add. 0x22 and 0x23 give subtract. 0x24 gives and, 0x25 or, 0x26 xor, 0x27 nor, 0x2a signed less-than and 0x2b unsigned less-than.
- R8: The immediate-form lines set register write and the immediate operand, plus the ALU code. Opcodes 0x08 and 0x09 give add. 0x0a gives signed less-than, 0x0b unsigned less-than and 0x0f load-upper. Opcodes 0x0c, 0x0d and 0x0e give and, or and xor, and also set zero-extend.
- R9: Opcode 0x23 (load) sets register write, immediate operand, load-to-register and ALU add. Opcode 0x2b (store) sets immediate operand, memory write and ALU add.
- R10: Control-flow lines:
  - opcode 0x04: branch on equal, ALU subtract
  - opcode 0x05: branch on not equal, ALU subtract
  - opcode 0x02: jump
  - opcode 0x03: jump, link and register write
  - function 0x08 under opcode 0: jump to register
  - opcode 0x20: halt
- R11: At most one of branch-equal, branch-not-equal, jump, jump-to-register and halt is set in any word. Memory write is never set together with register write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, clears the output register |
| opcode | input | OPC_W (6) | Instruction opcode field |
| funct | input | FN_W (6) | Instruction function field, used only when opcode is 0 |
| ctl_word | output | 16 | Registered control word, layout per R6 |

## Verification
The bench builds the decoder with its default widths: a 6-bit opcode and a 6-bit function field. At these widths, all 4096 opcode/function pairs can be swept one by one. Each result is compared with a word the bench assembles from the bit layout and instruction lists. The sweep therefore reaches every table line in both halves, including every unprogrammed one. It also covers every nonzero opcode paired with every function value, which shows the function field is ignored there. Targeted checks add the reset clearing, the one-edge latency, the hold between edges and the ALU code values.

// File: rtl/ctl_lut_pkg.sv
package ctl_lut_pkg;

  typedef enum logic [3:0] {
    ALU_ADD  = 4'd0,
    ALU_SUB  = 4'd1,
    ALU_AND  = 4'd2,
    ALU_OR   = 4'd3,
    ALU_NOR  = 4'd4,
    ALU_XOR  = 4'd5,
    ALU_SLT  = 4'd6,
    ALU_SLTU = 4'd7,
    ALU_LUI  = 4'd8
  } alu_op_e;

  // Declared MSB first; bit 0 is reg_wr.
  typedef struct packed {
    logic    halt;
    logic    zext;
    logic    jmp_reg;
    logic    link;
    logic    jmp;
    logic    br_ne;
    logic    br_eq;
    logic    mem_to_reg;
    logic    mem_wr;
    alu_op_e alu_op;
    logic    alu_imm;
    logic    dst_rd;
    logic    reg_wr;
  } ctl_word_t;

  localparam int CTL_W = $bits(ctl_word_t);

  // Opcode values (lower half of the table)
  localparam int OP_J     = 'h02;
  localparam int OP_JAL   = 'h03;
  localparam int OP_BEQ   = 'h04;
  localparam int OP_BNE   = 'h05;
  localparam int OP_ADDI  = 'h08;
  localparam int OP_ADDIU = 'h09;
  localparam int OP_SLTI  = 'h0a;
  localparam int OP_SLTIU = 'h0b;
  localparam int OP_ANDI  = 'h0c;
  localparam int OP_ORI   = 'h0d;
  localparam int OP_XORI  = 'h0e;
  localparam int OP_LUI   = 'h0f;
  localparam int OP_HALT  = 'h20;
  localparam int OP_LW    = 'h23;
  localparam int OP_SW    = 'h2b;

  // Function values (upper half of the table)
  localparam int FN_JR    = 'h08;
  localparam int FN_ADD   = 'h20;
  localparam int FN_ADDU  = 'h21;
  localparam int FN_SUB   = 'h22;
  localparam int FN_SUBU  = 'h23;
  localparam int FN_AND   = 'h24;
  localparam int FN_OR    = 'h25;
  localparam int FN_XOR   = 'h26;
  localparam int FN_NOR   = 'h27;
  localparam int FN_SLT   = 'h2a;
  localparam int FN_SLTU  = 'h2b;

  function automatic ctl_word_t reg_form(alu_op_e op);
    ctl_word_t w = '0;
    w.reg_wr = 1'b1;
    w.dst_rd = 1'b1;
    w.alu_op = op;
    return w;
  endfunction

  function automatic ctl_word_t imm_form(alu_op_e op, logic zx);
    ctl_word_t w = '0;
    w.reg_wr  = 1'b1;
    w.alu_imm = 1'b1;
    w.alu_op  = op;
    w.zext    = zx;
    return w;
  endfunction

  // Contents of one table line; half is the first line of the function half.
  function automatic ctl_word_t rom_line(int idx, int half);
    ctl_word_t w = '0;
    if (idx < half) begin
      case (idx)
        OP_ADDI, OP_ADDIU: w = imm_form(ALU_ADD, 1'b0);
        OP_SLTI:  w = imm_form(ALU_SLT, 1'b0);
        OP_SLTIU: w = imm_form(ALU_SLTU, 1'b0);
        OP_LUI:   w = imm_form(ALU_LUI, 1'b0);
        OP_ANDI:  w = imm_form(ALU_AND, 1'b1);
        OP_ORI:   w = imm_form(ALU_OR, 1'b1);
        OP_XORI:  w = imm_form(ALU_XOR, 1'b1);
        OP_LW: begin
          w = imm_form(ALU_ADD, 1'b0);
          w.mem_to_reg = 1'b1;
        end
        OP_SW: begin
          w.alu_imm = 1'b1;
          w.mem_wr  = 1'b1;
        end
        OP_BEQ: begin
          w.br_eq  = 1'b1;
          w.alu_op = ALU_SUB;
        end
        OP_BNE: begin
          w.br_ne  = 1'b1;
          w.alu_op = ALU_SUB;
        end
        OP_J:    w.jmp = 1'b1;
        OP_JAL: begin
          w.jmp    = 1'b1;
          w.link   = 1'b1;
          w.reg_wr = 1'b1;
        end
        OP_HALT: w.halt = 1'b1;
        default: w = '0;
      endcase
    end else begin
      case (idx - half)
        FN_ADD, FN_ADDU: w = reg_form(ALU_ADD);
        FN_SUB, FN_SUBU: w = reg_form(ALU_SUB);
        FN_AND:  w = reg_form(ALU_AND);
        FN_OR:   w = reg_form(ALU_OR);
        FN_XOR:  w = reg_form(ALU_XOR);
        FN_NOR:  w = reg_form(ALU_NOR);
        FN_SLT:  w = reg_form(ALU_SLT);
        FN_SLTU: w = reg_form(ALU_SLTU);
        FN_JR:   w.jmp_reg = 1'b1;
        default: w = '0;
      endcase
    end
    return w;
  endfunction

endpackage

// File: rtl/ctl_index_mux.sv
module ctl_index_mux #(
  parameter int OPC_W = 6,
  parameter int FN_W  = 6,
  localparam int IDX_W = OPC_W + 1
) (
  input  logic [OPC_W-1:0] opcode,
  input  logic [FN_W-1:0]  funct,
  output logic [IDX_W-1:0] idx
);

  logic             reg_form;
  logic [OPC_W-1:0] fn_ext;

  assign fn_ext   = OPC_W'(funct);
  assign reg_form = (opcode == '0);

  always_comb begin
    if (reg_form) idx = {1'b1, fn_ext};
    else          idx = {1'b0, opcode};
  end

  // R1 / R2: the top index bit alone tells which half was chosen
  always_comb begin
    // R2
    half_sel_chk: assert (idx[IDX_W-1] == (opcode == '0));
  end

endmodule

// File: rtl/ctl_rom.sv
module ctl_rom
  import ctl_lut_pkg::*;
#(
  parameter int IDX_W = 7,
  localparam int DEPTH = 1 << IDX_W,
  localparam int HALF  = DEPTH / 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] idx,
  output logic [CTL_W-1:0] q
);

  logic [CTL_W-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = rom_line(i, HALF);
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= mem[idx];
  end

endmodule

// File: rtl/ctl_lut_decoder.sv
module ctl_lut_decoder
  import ctl_lut_pkg::*;
#(
  parameter int OPC_W = 6,
  parameter int FN_W  = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [OPC_W-1:0] opcode,
  input  logic [FN_W-1:0]  funct,
  output logic [CTL_W-1:0] ctl_word
);

  localparam int IDX_W = OPC_W + 1;

  logic [IDX_W-1:0] idx;
  ctl_word_t        cw;

  ctl_index_mux #(.OPC_W(OPC_W), .FN_W(FN_W)) u_idx (
    .opcode (opcode),
    .funct  (funct),
    .idx    (idx)
  );

  ctl_rom #(.IDX_W(IDX_W)) u_rom (
    .clk (clk),
    .rst (rst),
    .idx (idx),
    .q   (ctl_word)
  );

  assign cw = ctl_word_t'(ctl_word);

  // R11
  flow_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cw.br_eq, cw.br_ne, cw.jmp, cw.jmp_reg, cw.halt}));

  // R11
  wr_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(cw.mem_wr && cw.reg_wr));

  // R9
  load_path_chk: assert property (@(posedge clk) disable iff (rst)
    cw.mem_to_reg |-> (cw.reg_wr && cw.alu_imm));

  // R10
  jr_decode_chk: assert property (@(posedge clk) disable iff (rst)
    (opcode == '0 && funct == FN_W'(FN_JR)) |=> cw.jmp_reg);

  // R1
  lw_decode_chk: assert property (@(posedge clk) disable iff (rst)
    (opcode == OPC_W'(OP_LW)) |=> (cw.mem_to_reg && !cw.dst_rd));

  // R5
  null_line_chk: assert property (@(posedge clk) disable iff (rst)
    (opcode == '0 && funct == '0) |=> (ctl_word == '0));

endmodule

// File: tb/ctl_lut_decoder_test.sv
`timescale 1ns/1ps
module ctl_lut_decoder_test;

  localparam int OPC_W = 6;
  localparam int FN_W  = 6;

  localparam int B_RW = 0, B_DST = 1, B_IMM = 2, B_ALU = 3, B_MW = 7, B_M2R = 8;
  localparam int B_BEQ = 9, B_BNE = 10, B_J = 11, B_LNK = 12, B_JR = 13, B_ZX = 14, B_HLT = 15;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [OPC_W-1:0] opcode = '0;
  logic [FN_W-1:0]  funct = '0;
  logic [15:0]      ctl_word;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  ctl_lut_decoder #(.OPC_W(OPC_W), .FN_W(FN_W)) uut (
    .clk      (clk),
    .rst      (rst),
    .opcode   (opcode),
    .funct    (funct),
    .ctl_word (ctl_word)
  );

  function automatic logic [15:0] rf(int alu);
    return 16'((1 << B_RW) | (1 << B_DST) | (alu << B_ALU));
  endfunction

  function automatic logic [15:0] im(int alu, int zx);
    return 16'((1 << B_RW) | (1 << B_IMM) | (alu << B_ALU) | (zx << B_ZX));
  endfunction

  // Expected word from R2/R5..R10
  function automatic logic [15:0] expect_word(int op, int fn);
    if (op != 0) begin
      case (op)
        'h08, 'h09: return im(0, 0);
        'h0a: return im(6, 0);
        'h0b: return im(7, 0);
        'h0f: return im(8, 0);
        'h0c: return im(2, 1);
        'h0d: return im(3, 1);
        'h0e: return im(5, 1);
        'h23: return im(0, 0) | 16'(1 << B_M2R);
        'h2b: return 16'((1 << B_IMM) | (1 << B_MW));
        'h04: return 16'((1 << B_BEQ) | (1 << B_ALU));
        'h05: return 16'((1 << B_BNE) | (1 << B_ALU));
        'h02: return 16'(1 << B_J);
        'h03: return 16'((1 << B_J) | (1 << B_LNK) | (1 << B_RW));
        'h20: return 16'(1 << B_HLT);
        default: return 16'h0;
      endcase
    end
    case (fn)
      'h20, 'h21: return rf(0);
      'h22, 'h23: return rf(1);
      'h24: return rf(2);
      'h25: return rf(3);
      'h26: return rf(5);
      'h27: return rf(4);
      'h2a: return rf(6);
      'h2b: return rf(7);
      'h08: return 16'(1 << B_JR);
      default: return 16'h0;
    endcase
  endfunction

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s op=%h fn=%h actual=%h expected=%h", tag, opcode, funct, act, exp);
    end
  endtask

  task automatic apply(int op, int fn);
    @(negedge clk);
    opcode = OPC_W'(op);
    funct  = FN_W'(fn);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] held;
    // R4: reset clears output even with a load presented
    opcode = 6'h23;
    repeat (3) @(negedge clk);
    chk("R4 reset", ctl_word, 16'h0);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R9 load after reset", ctl_word, expect_word('h23, 0));

    // R2: add lands on line 0x60
    apply(0, 'h20);
    chk("R2 add", ctl_word, rf(0));

    // R3: new fields do not reach the output before the edge
    @(negedge clk);
    opcode = 6'h00;
    funct  = 6'h22;
    #1;
    held = ctl_word;
    chk("R3 hold", held, rf(0));
    @(negedge clk);
    chk("R3 latency", ctl_word, rf(1));

    // R6: ALU code field values
    apply(0, 'h26); chk("R6 xor code", {12'h0, ctl_word[6:3]}, 16'd5);
    apply(0, 'h2b); chk("R6 sltu code", {12'h0, ctl_word[6:3]}, 16'd7);
    apply('h0f, 0); chk("R6 lui code", {12'h0, ctl_word[6:3]}, 16'd8);
    apply('h04, 0); chk("R6 sub code", {12'h0, ctl_word[6:3]}, 16'd1);

    // R7..R10 named instructions
    apply(0, 'h27);   chk("R7 nor", ctl_word, rf(4));
    apply('h0c, 'h3f); chk("R8 andi", ctl_word, im(2, 1));
    apply('h2b, 0);   chk("R9 store", ctl_word, 16'h0084);
    apply('h03, 'h08); chk("R10 link jump", ctl_word, 16'h1801);
    apply(0, 'h08);   chk("R10 jump reg", ctl_word, 16'h2000);
    apply('h20, 0);   chk("R10 halt", ctl_word, 16'h8000);
    apply(0, 0);      chk("R5 null line", ctl_word, 16'h0);

    // R1 / R2 / R5 / R11: every opcode and function pair
    for (int op = 0; op < 64; op++) begin
      for (int fn = 0; fn < 64; fn++) begin
        apply(op, fn);
        chk(op == 0 ? "R2 sweep" : "R1 sweep", ctl_word, expect_word(op, fn));
        checks++;
        if (!$onehot0({ctl_word[B_BEQ], ctl_word[B_BNE], ctl_word[B_J],
                       ctl_word[B_JR], ctl_word[B_HLT]}) ||
            (ctl_word[B_MW] && ctl_word[B_RW])) begin
          fails++;
          $display("FAIL R11 op=%h fn=%h actual=%h expected=exclusive", op, fn, ctl_word);
        end
      end
    end

    // R4: reset mid-run clears the output again
    @(negedge clk);
    opcode = 6'h08;
    rst = 1'b1;
    @(negedge clk);
    chk("R4 reset mid-run", ctl_word, 16'h0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule